// File: doc/BRIEF.md
# C-Bit Application Identification Detector

This block watches a received T3 stream and reports whether its framing looks like C-bit parity or M23. Upstream logic locates each M frame and pulls out the first C bit of that frame. It presents that bit together with a one-cycle strobe. In C-bit parity framing the first C bit is held at one. In M23 framing the same bit carries the stuffing indication, so it moves between zero and one.

The detector groups the strobes into back-to-back, non-overlapping blocks of `BLOCK_FRAMES` M frames (1024 by default). In each block it counts how many of the sampled C bits were one. At the close of every block the status is rewritten: it becomes one if the count reached `SET_THRESH` (1020 by default), and zero otherwise. The status is a live level. It is not latched and nothing clears it as a side effect of being read. When the line runs in E3 mode the status has no meaning, so the block holds it at zero and starts counting afresh once T3 operation resumes.

Top module: `cbit_app_detect`

## Requirements
- R1: After reset `cbit_app` is 0, and it stays 0 until the first full block of 1024 strobes has completed.
- R2: When at least 1020 of the 1024 strobes in a block carried `first_cbit` = 1, `cbit_app` is 1 from the cycle after that block's last strobe.
- R3: When fewer than 1020 of the 1024 strobes in a block carried `first_cbit` = 1, `cbit_app` is 0 from the cycle after that block's last strobe. A C bit that alternates every frame therefore reads as 0.
- R4: `cbit_app` changes only in the cycle that follows a block's last strobe, or when `e3_mode` changes. Between those points it holds its value.
- R5: `first_cbit` is sampled only in cycles where `mframe_stb` is 1. Cycles without a strobe count neither as frames nor as ones.
- R6: While `e3_mode` is 1, `cbit_app` is 0 and the block's partial counts are discarded. After `e3_mode` returns to 0, a new block of 1024 strobes begins, and the status stays 0 until that block completes.
- R7: When `e3_mode` is 1 in the same cycle as a block's last strobe, E3 mode wins. No update takes place, and the status is 0 after `e3_mode` falls.
- R8: The C bit presented with a block's last strobe counts toward that block's decision. Exactly 1020 ones sets the status and 1019 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mframe_stb | input | 1 | One-cycle pulse marking each received M frame |
| first_cbit | input | 1 | Value of that M frame's first C bit, valid with `mframe_stb` |
| e3_mode | input | 1 | 1 when the line runs E3; forces the status to 0 |
| cbit_app | output | 1 | 1 = stream looks like C-bit parity, 0 = M23 or undecided |

## Verification
Two events can fall on the same clock edge: the closing strobe of a block and the entry into E3 mode. The bench fills a block with ones so that the status would be set, and raises `e3_mode` in exactly the cycle of the 1024th strobe. A reference model, stepped every clock, expects the status to stay 0 and the next block to start from zero. The bench also probes the thresholds: a block whose ones include the final strobe and total exactly 1020, and a block with 1019 ones whose idle cycles carry a one on `first_cbit`. Both blocks show whether the last sampled bit and the strobe gating are handled correctly.

// File: rtl/cbit_app_detect.sv
module cbit_app_detect #(
  parameter int BLOCK_FRAMES = 1024,
  parameter int SET_THRESH   = 1020
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mframe_stb,
  input  logic first_cbit,
  input  logic e3_mode,
  output logic cbit_app
);
  localparam int FW = $clog2(BLOCK_FRAMES);
  localparam int OW = $clog2(BLOCK_FRAMES + 1);

  logic [FW-1:0] frame_cnt;
  logic [OW-1:0] ones_cnt;
  logic          status_q;

  wire           take      = mframe_stb & ~e3_mode;
  wire           last      = (frame_cnt == FW'(BLOCK_FRAMES - 1));
  wire [OW-1:0]  ones_next = ones_cnt + OW'(first_cbit);

  always_ff @(posedge clk) begin
    if (!rst_n || e3_mode) begin
      frame_cnt <= '0;
      ones_cnt  <= '0;
      status_q  <= 1'b0;
    end else if (take) begin
      if (last) begin
        status_q  <= (ones_next >= OW'(SET_THRESH));
        frame_cnt <= '0;
        ones_cnt  <= '0;
      end else begin
        frame_cnt <= frame_cnt + 1'b1;
        ones_cnt  <= ones_next;
      end
    end
  end

  assign cbit_app = status_q & ~e3_mode;

  // R4: status only moves at a block end or on E3 entry
  a_r4_hold_between_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (!e3_mode && !(take && last)) |=> $stable(status_q));

  // R2: a rising status must follow a closing strobe
  a_r2_rise_at_block_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(take && last));

  // R6: E3 wipes the counters and the status
  a_r6_e3_clears: assert property (@(posedge clk) disable iff (!rst_n)
    e3_mode |=> (status_q == 1'b0 && frame_cnt == '0 && ones_cnt == '0));

  // R5: idle cycles leave the counters untouched
  a_r5_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!mframe_stb && !e3_mode) |=> ($stable(frame_cnt) && $stable(ones_cnt)));

  // R5: ones can never outnumber frames seen in the block
  a_r5_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ones_cnt) <= 32'(frame_cnt));
endmodule

// File: tb/cbit_app_detect_test.sv
`timescale 1ns/1ps
module cbit_app_detect_test;
  localparam int BLK = 1024;
  localparam int THR = 1020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mframe_stb = 1'b0;
  logic first_cbit = 1'b0;
  logic e3_mode = 1'b0;
  logic cbit_app;

  int vectors = 0;
  int fails = 0;
  string tag = "R1";

  int m_frames = 0;
  int m_ones = 0;
  bit m_stat = 1'b0;

  always #2.5 clk = ~clk;

  cbit_app_detect #(.BLOCK_FRAMES(BLK), .SET_THRESH(THR)) uut (
    .clk(clk), .rst_n(rst_n), .mframe_stb(mframe_stb),
    .first_cbit(first_cbit), .e3_mode(e3_mode), .cbit_app(cbit_app));

  always @(posedge clk) begin
    if (!rst_n || e3_mode) begin
      m_frames = 0; m_ones = 0; m_stat = 1'b0;
    end else if (mframe_stb) begin
      m_ones += int'(first_cbit);
      m_frames++;
      if (m_frames == BLK) begin
        m_stat = (m_ones >= THR);
        m_frames = 0; m_ones = 0;
      end
    end
  end

  function automatic bit expected();
    return e3_mode ? 1'b0 : m_stat;
  endfunction

  task automatic compare(string req);
    vectors++;
    if (cbit_app !== expected()) begin
      fails++;
      $display("FAIL %s: cbit_app=%b expected=%b at %0t", req, cbit_app, expected(), $time);
    end
  endtask

  task automatic cyc(bit stb, bit cb, bit e3);
    @(negedge clk);
    compare(tag);
    mframe_stb = stb; first_cbit = cb; e3_mode = e3;
  endtask

  task automatic frame(bit cb, int gap);
    for (int g = 0; g < gap; g++) cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b1, cb, 1'b0);
  endtask

  task automatic block_with_ones(int ones, int gap);
    for (int i = 0; i < BLK; i++) frame((i >= BLK - ones), gap);
  endtask

  task automatic expect_level(string req, bit val);
    @(negedge clk);
    vectors++;
    if (cbit_app !== val) begin
      fails++;
      $display("FAIL %s: cbit_app=%b expected=%b at %0t", req, cbit_app, val, $time);
    end
    mframe_stb = 1'b0; first_cbit = 1'b0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    expect_level("R1", 1'b0);
    for (int i = 0; i < BLK - 1; i++) frame(1'b1, 0);
    expect_level("R1", 1'b0);
    tag = "R2";
    frame(1'b1, 0);
    expect_level("R2", 1'b1);
    tag = "R8";
    block_with_ones(THR, 0);
    expect_level("R8", 1'b1);
    tag = "R5";
    block_with_ones(THR - 1, 2);
    expect_level("R5", 1'b0);
    tag = "R2";
    block_with_ones(BLK, 1);
    expect_level("R2", 1'b1);
    tag = "R3";
    for (int i = 0; i < BLK; i++) frame(i[0], 0);
    expect_level("R3", 1'b0);
    tag = "R4";
    block_with_ones(THR + 2, 0);
    for (int i = 0; i < 600; i++) frame(1'b1, 0);
    expect_level("R4", 1'b1);
    tag = "R6";
    cyc(1'b1, 1'b1, 1'b1);
    expect_level("R6", 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < BLK - 1; i++) frame(1'b1, 0);
    expect_level("R6", 1'b0);
    frame(1'b1, 0);
    expect_level("R6", 1'b1);
    tag = "R7";
    for (int i = 0; i < BLK - 1; i++) frame(1'b1, 0);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    expect_level("R7", 1'b0);
    for (int i = 0; i < BLK; i++) frame(1'b1, 0);
    expect_level("R7", 1'b1);
    tag = "R4";
    repeat (20) cyc(1'b0, 1'b0, 1'b0);
    expect_level("R4", 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule